// File: doc/BRIEF.md
# Byte-wide bidirectional GPIO port with pull-up control

This block is an eight-pin general-purpose I/O port attached to a simple byte-wide register bus. It stores an output data latch and a per-pin direction mask. For every pin it produces three pad controls: an output enable, an output value and a pull-up enable. The latch bit of an input pin selects its pull-up. The levels actually present on the pads are read at their own address, after a two-flop synchronizer, and not from the latch.

Software changes a single bit of the latch or of the direction mask with a one-cycle bit-set or bit-clear operation, so no read-modify-write sequence is needed. An alternate-function enable gives the pads to an external multiplexed address/data bus. In that mode the bus supplies the drive value and the direction, the pull-ups are forced on, and the stored registers stay untouched until the port returns to general-purpose mode.

Top module: `gpio_port`

## Requirements
- R1: After synchronous reset the latch and the direction mask are 0x00, so pad_oe, pad_out and pad_pu are all zero while alt_en is 0.
- R2: A cycle with bus_wr high stores bus_wdata into the latch at address 0x1B or into the direction mask at address 0x1A on that clock edge. A read of either address returns the stored byte.
- R3: With alt_en low, pad_oe[n] equals direction bit n. pad_out[n] equals latch bit n when direction bit n is 1, and is 0 when direction bit n is 0.
- R4: With alt_en low, pad_pu[n] is 1 exactly when latch bit n is 1 and direction bit n is 0.
- R5: A read of address 0x19 returns pad_in as sampled two rising edges earlier, through a two-flop synchronizer.
- R6: A cycle with bus_bitop high at 0x1B or 0x1A sets bit bus_bitidx of that register when bus_bitset is 1 and clears it when bus_bitset is 0. The change lands in one clock, and every other bit keeps its value.
- R7: When bus_wr and bus_bitop are high in the same cycle, the full-byte write wins and the bit operation is dropped.
- R8: Writes and bit operations at 0x19 change neither the latch nor the direction mask. While bus_rd is high, a read of any address other than 0x19, 0x1A and 0x1B returns 0x00. While bus_rd is low, bus_rdata is 0x00.
- R9: With alt_en high, every pad_oe bit equals alt_oe, pad_out equals alt_out and pad_pu is 0xFF, whatever the latch and direction mask hold.
- R10: Writes and bit operations while alt_en is high still update the stored registers. They can be read back, and they drive the pads once alt_en returns low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 6 | Register address |
| bus_wdata | input | 8 | Full-byte write data |
| bus_wr | input | 1 | Full-byte write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_bitop | input | 1 | Single-bit operation strobe |
| bus_bitidx | input | 3 | Bit index for the single-bit operation |
| bus_bitset | input | 1 | 1 sets the bit, 0 clears it |
| bus_rdata | output | 8 | Read data, combinational |
| alt_en | input | 1 | Hands the pads to the external address/data bus |
| alt_oe | input | 1 | Direction from the external bus (1 drives) |
| alt_out | input | 8 | Drive value from the external bus |
| pad_in | input | 8 | Asynchronous pad levels |
| pad_oe | output | 8 | Per-pin output enable |
| pad_out | output | 8 | Per-pin output value |
| pad_pu | output | 8 | Per-pin pull-up enable |

## Verification
On every cycle the assertions check the pad-control mapping in both modes, the pull-up rule, the isolation of single-bit operations, the immunity of the stored registers to the read-only address, the zero returned for unmapped reads and the two-edge latency of the pin read. The bench's scenarios are needed for the rest. They show the reset values, write-over-bit-operation priority, and writes stored under the alternate function that take effect only after release. They also sweep every latch value against several direction patterns and every pad value through the synchronizer.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    parameter int unsigned PORT_W  = 8;
    parameter int unsigned ADDR_W  = 6;
    parameter int unsigned SYNC_ST = 2;
    localparam int unsigned IDX_W  = $clog2(PORT_W);

    localparam logic [ADDR_W-1:0] PIN_OFS   = ADDR_W'(8'h19);
    localparam logic [ADDR_W-1:0] DIR_OFS   = ADDR_W'(8'h1A);
    localparam logic [ADDR_W-1:0] LATCH_OFS = ADDR_W'(8'h1B);

    typedef logic [PORT_W-1:0] port_vec_t;

    typedef enum logic [1:0] {
        SEL_NONE  = 2'd0,
        SEL_PIN   = 2'd1,
        SEL_DIR   = 2'd2,
        SEL_LATCH = 2'd3
    } reg_sel_e;

    typedef struct packed {
        port_vec_t oe;
        port_vec_t out;
        port_vec_t pu;
    } pad_ctl_t;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        if (a == LATCH_OFS)      s = SEL_LATCH;
        else if (a == DIR_OFS)   s = SEL_DIR;
        else if (a == PIN_OFS)   s = SEL_PIN;
        else                     s = SEL_NONE;
        return s;
    endfunction

    function automatic port_vec_t bit_update(input port_vec_t cur,
                                             input logic [IDX_W-1:0] idx,
                                             input logic set);
        port_vec_t r;
        r = cur;
        r[idx] = set;
        return r;
    endfunction

endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_port_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  reg_sel_e         sel,
    input  logic             wr,
    input  port_vec_t        wdata,
    input  logic             bitop,
    input  logic [IDX_W-1:0] bitidx,
    input  logic             bitset,
    output port_vec_t        latch_q,
    output port_vec_t        dir_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= '0;
            dir_q   <= '0;
        end else if (wr) begin
            case (sel)
                SEL_LATCH: latch_q <= wdata;
                SEL_DIR:   dir_q   <= wdata;
                default:   ;
            endcase
        end else if (bitop) begin
            case (sel)
                SEL_LATCH: latch_q <= bit_update(latch_q, bitidx, bitset);
                SEL_DIR:   dir_q   <= bit_update(dir_q, bitidx, bitset);
                default:   ;
            endcase
        end
    end

endmodule

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
    parameter int unsigned W      = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[g] <= '0;
                else     stg[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[g] <= '0;
                else     stg[g] <= stg[g-1];
            end
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux
    import gpio_port_pkg::*;
(
    input  port_vec_t latch_q,
    input  port_vec_t dir_q,
    input  logic      alt_en,
    input  logic      alt_oe,
    input  port_vec_t alt_out,
    output pad_ctl_t  ctl
);

    port_vec_t oe_v, out_v, pu_v;

    for (genvar n = 0; n < PORT_W; n++) begin : g_pin
        assign oe_v[n]  = alt_en ? alt_oe     : dir_q[n];
        assign out_v[n] = alt_en ? alt_out[n] : (dir_q[n] & latch_q[n]);
        assign pu_v[n]  = alt_en ? 1'b1       : (~dir_q[n] & latch_q[n]);
    end

    assign ctl = '{oe: oe_v, out: out_v, pu: pu_v};

endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [PORT_W-1:0] bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic              bus_bitop,
    input  logic [IDX_W-1:0]  bus_bitidx,
    input  logic              bus_bitset,
    output logic [PORT_W-1:0] bus_rdata,
    input  logic              alt_en,
    input  logic              alt_oe,
    input  logic [PORT_W-1:0] alt_out,
    input  logic [PORT_W-1:0] pad_in,
    output logic [PORT_W-1:0] pad_oe,
    output logic [PORT_W-1:0] pad_out,
    output logic [PORT_W-1:0] pad_pu
);

    reg_sel_e  sel;
    port_vec_t latch_q, dir_q, pin_s;
    pad_ctl_t  ctl;

    assign sel = decode_addr(bus_addr);

    gpio_port_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .sel     (sel),
        .wr      (bus_wr),
        .wdata   (bus_wdata),
        .bitop   (bus_bitop),
        .bitidx  (bus_bitidx),
        .bitset  (bus_bitset),
        .latch_q (latch_q),
        .dir_q   (dir_q)
    );

    gpio_pin_sync #(.W(PORT_W), .STAGES(SYNC_ST)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pad_in),
        .q   (pin_s)
    );

    gpio_pad_mux u_mux (
        .latch_q (latch_q),
        .dir_q   (dir_q),
        .alt_en  (alt_en),
        .alt_oe  (alt_oe),
        .alt_out (alt_out),
        .ctl     (ctl)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (sel)
                SEL_LATCH: bus_rdata = latch_q;
                SEL_DIR:   bus_rdata = dir_q;
                SEL_PIN:   bus_rdata = pin_s;
                default:   bus_rdata = '0;
            endcase
        end
    end

    assign pad_oe  = ctl.oe;
    assign pad_out = ctl.out;
    assign pad_pu  = ctl.pu;

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
    import gpio_port_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic              bus_bitop,
    input logic [IDX_W-1:0]  bus_bitidx,
    input logic              bus_bitset,
    input logic [PORT_W-1:0] bus_rdata,
    input logic              alt_en,
    input logic              alt_oe,
    input logic [PORT_W-1:0] alt_out,
    input logic [PORT_W-1:0] pad_in,
    input logic [PORT_W-1:0] pad_oe,
    input logic [PORT_W-1:0] pad_out,
    input logic [PORT_W-1:0] pad_pu,
    input logic [PORT_W-1:0] latch_q,
    input logic [PORT_W-1:0] dir_q
);

    localparam port_vec_t ONE = port_vec_t'(1);

    logic [1:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst)                  since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    logic lat_bitop, mapped;
    assign lat_bitop = bus_bitop && !bus_wr && (bus_addr == LATCH_OFS);
    assign mapped    = (bus_addr == LATCH_OFS) || (bus_addr == DIR_OFS) || (bus_addr == PIN_OFS);

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && !alt_en) |-> (pad_oe == '0 && pad_pu == '0 && pad_out == '0));

    // R3
    gp_drive_chk: assert property (@(posedge clk) disable iff (rst)
        !alt_en |-> (pad_oe == dir_q && (pad_out & ~dir_q) == '0 && (pad_out & dir_q) == (latch_q & dir_q)));

    // R4
    pullup_chk: assert property (@(posedge clk) disable iff (rst)
        !alt_en |-> ((pad_pu & dir_q) == '0 && (pad_pu & ~dir_q) == (latch_q & ~dir_q)));

    // R5
    pin_latency_chk: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2 && bus_rd && bus_addr == PIN_OFS) |-> bus_rdata == $past(pad_in, 2));

    // R6
    bitop_isolate_chk: assert property (@(posedge clk) disable iff (rst)
        lat_bitop |=> (((latch_q ^ $past(latch_q)) & ~(ONE << $past(bus_bitidx))) == '0
                       && latch_q[$past(bus_bitidx)] == $past(bus_bitset)));

    // R8
    pin_addr_ro_chk: assert property (@(posedge clk) disable iff (rst)
        ((bus_wr || bus_bitop) && bus_addr == PIN_OFS) |=> ($stable(latch_q) && $stable(dir_q)));

    // R8
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
        ((bus_rd && !mapped) || !bus_rd) |-> bus_rdata == '0);

    // R9
    alt_override_chk: assert property (@(posedge clk) disable iff (rst)
        alt_en |-> (pad_oe == {PORT_W{alt_oe}} && pad_out == alt_out && pad_pu == '1));

endmodule

bind gpio_port gpio_port_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_bitop  (bus_bitop),
    .bus_bitidx (bus_bitidx),
    .bus_bitset (bus_bitset),
    .bus_rdata  (bus_rdata),
    .alt_en     (alt_en),
    .alt_oe     (alt_oe),
    .alt_out    (alt_out),
    .pad_in     (pad_in),
    .pad_oe     (pad_oe),
    .pad_out    (pad_out),
    .pad_pu     (pad_pu),
    .latch_q    (latch_q),
    .dir_q      (dir_q)
);

// File: tb/gpio_port_bench.sv
`timescale 1ns/1ps
module gpio_port_bench;

    localparam logic [5:0] A_PIN = 6'h19, A_DIR = 6'h1A, A_LAT = 6'h1B;

    logic       clk = 1'b0;
    logic       rst;
    logic [5:0] bus_addr;
    logic [7:0] bus_wdata;
    logic       bus_wr, bus_rd, bus_bitop, bus_bitset;
    logic [2:0] bus_bitidx;
    logic [7:0] bus_rdata;
    logic       alt_en, alt_oe;
    logic [7:0] alt_out, pad_in, pad_oe, pad_out, pad_pu;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    gpio_port u_gpio_port (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_bitop(bus_bitop),
        .bus_bitidx(bus_bitidx), .bus_bitset(bus_bitset), .bus_rdata(bus_rdata),
        .alt_en(alt_en), .alt_oe(alt_oe), .alt_out(alt_out), .pad_in(pad_in),
        .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bit_op(input logic [5:0] a, input logic [2:0] i, input logic s);
        @(negedge clk);
        bus_addr = a; bus_bitidx = i; bus_bitset = s; bus_bitop = 1'b1;
        @(negedge clk);
        bus_bitop = 1'b0;
    endtask

    task automatic rd_reg(input logic [5:0] a, output logic [7:0] v);
        bus_addr = a; bus_rd = 1'b1;
        #0.5;
        v = bus_rdata;
        bus_rd = 1'b0;
        #0.5;
    endtask

    task automatic check_pads(input string req, input logic [7:0] lat, input logic [7:0] dir);
        chk(req, pad_oe, dir);
        chk(req, pad_out, lat & dir);
        chk(req, pad_pu, lat & ~dir);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [7:0] v, lat, dir, prev;
        logic [7:0] dirs [8];
        dirs = '{8'h00, 8'hFF, 8'h0F, 8'hF0, 8'hAA, 8'h55, 8'h81, 8'h3C};

        rst = 1'b1; bus_addr = '0; bus_wdata = '0; bus_wr = 0; bus_rd = 0;
        bus_bitop = 0; bus_bitidx = '0; bus_bitset = 0;
        alt_en = 0; alt_oe = 0; alt_out = '0; pad_in = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        @(negedge clk);
        check_pads("R1", 8'h00, 8'h00);
        rd_reg(A_LAT, v); chk("R1", v, 8'h00);
        rd_reg(A_DIR, v); chk("R1", v, 8'h00);

        // R2 R3 R4: sweep every latch value against several direction masks
        foreach (dirs[k]) begin
            wr_reg(A_DIR, dirs[k]);
            for (int l = 0; l < 256; l++) begin
                wr_reg(A_LAT, 8'(l));
                check_pads("R3", 8'(l), dirs[k]);
                chk("R4", pad_pu, 8'(l) & ~dirs[k]);
                rd_reg(A_LAT, v); chk("R2", v, 8'(l));
            end
            rd_reg(A_DIR, v); chk("R2", v, dirs[k]);
        end

        // R6: single-bit set and clear on both registers
        for (int r = 0; r < 2; r++) begin
            logic [5:0] a;
            a = (r == 0) ? A_LAT : A_DIR;
            for (int p = 0; p < 2; p++) begin
                logic [7:0] exp;
                exp = (p == 0) ? 8'hA5 : 8'h5A;
                wr_reg(a, exp);
                for (int i = 0; i < 8; i++) begin
                    bit_op(a, 3'(i), 1'b1);
                    exp[i] = 1'b1;
                    rd_reg(a, v); chk("R6", v, exp);
                    bit_op(a, 3'(i), 1'b0);
                    exp[i] = 1'b0;
                    rd_reg(a, v); chk("R6", v, exp);
                    bit_op(a, 3'(i), 1'b1);
                    exp[i] = 1'b1;
                    rd_reg(a, v); chk("R6", v, exp);
                end
            end
        end

        // R7: full write beats a bit op in the same cycle
        wr_reg(A_LAT, 8'h00);
        @(negedge clk);
        bus_addr = A_LAT; bus_wdata = 8'h3C; bus_wr = 1; bus_bitop = 1;
        bus_bitidx = 3'd0; bus_bitset = 1;
        @(negedge clk);
        bus_wr = 0; bus_bitop = 0;
        rd_reg(A_LAT, v); chk("R7", v, 8'h3C);

        // R8: read-only pin address, unmapped and idle reads
        wr_reg(A_LAT, 8'h96);
        wr_reg(A_DIR, 8'h69);
        wr_reg(A_PIN, 8'hFF);
        bit_op(A_PIN, 3'd0, 1'b1);
        bit_op(A_PIN, 3'd1, 1'b0);
        rd_reg(A_LAT, v); chk("R8", v, 8'h96);
        rd_reg(A_DIR, v); chk("R8", v, 8'h69);
        check_pads("R8", 8'h96, 8'h69);
        for (int a = 0; a < 64; a++) begin
            if (6'(a) != A_PIN && 6'(a) != A_DIR && 6'(a) != A_LAT) begin
                rd_reg(6'(a), v); chk("R8", v, 8'h00);
            end
        end
        bus_addr = A_LAT; bus_rd = 1'b0; #0.5;
        chk("R8", bus_rdata, 8'h00);

        // R5: pin path, one edge shows the old value, two edges the new one
        prev = pad_in;
        for (int p = 0; p < 256; p++) begin
            logic [7:0] nv;
            nv = 8'(p) ^ 8'h5B;
            @(negedge clk);
            pad_in = nv;
            @(negedge clk);
            rd_reg(A_PIN, v); chk("R5", v, prev);
            @(negedge clk);
            rd_reg(A_PIN, v); chk("R5", v, nv);
            prev = nv;
        end

        // R9: alternate function overrides direction and pull-ups
        wr_reg(A_LAT, 8'hC3);
        wr_reg(A_DIR, 8'h0F);
        @(negedge clk);
        alt_en = 1'b1;
        for (int o = 0; o < 2; o++) begin
            for (int d = 0; d < 256; d++) begin
                alt_oe = o[0]; alt_out = 8'(d);
                #0.5;
                chk("R9", pad_oe, {8{o[0]}});
                chk("R9", pad_out, 8'(d));
                chk("R9", pad_pu, 8'hFF);
                #0.5;
            end
        end

        // R10: register updates under the alternate function apply after release
        lat = 8'h3C; dir = 8'hE1;
        wr_reg(A_LAT, lat);
        wr_reg(A_DIR, 8'h00);
        bit_op(A_DIR, 3'd0, 1'b1);
        bit_op(A_DIR, 3'd5, 1'b1);
        bit_op(A_DIR, 3'd6, 1'b1);
        bit_op(A_DIR, 3'd7, 1'b1);
        chk("R10", pad_pu, 8'hFF);
        rd_reg(A_LAT, v); chk("R10", v, lat);
        rd_reg(A_DIR, v); chk("R10", v, dir);
        alt_en = 1'b0;
        #0.5;
        check_pads("R10", lat, dir);

        done = 1'b1;
        finish_run();
    end

endmodule